// File: doc/BRIEF.md
# Instruction Dispatch with Register Alias Table

This block is the issue front end of an out-of-order integer core. Each cycle it presents a byte address to an instruction memory and decodes the 32-bit word that comes back. It accepts register-register add, subtract, multiply and divide, and the word load. For every source register it consults a register alias table. A register with no pending writer is sent as a ready value read from the architectural register file. A register with a pending writer is sent as the reorder-buffer tag of that writer. When the instruction can go, the block hands it to a free reservation station of the right kind, takes the reorder-buffer tag offered at its input, and records that tag as the newest writer of the destination register.

Station occupancy, reorder-buffer fullness, the next free tag and in-order commits all come from neighbouring blocks. The issue packet is registered, so it appears the cycle after the instruction word was decoded. A result broadcast on the common result bus in the issue cycle is not captured here; the station picks it up one cycle later. A commit in the issue cycle is forwarded, because it is the last chance to see that value before the register file takes it.

Top module: `issue_front`

## Requirements
- R1: While reset is asserted, `iss_valid` is 0 and `imem_addr` is 0, and reset empties every alias-table entry, so that every later source with no new writer reads the register file.
- R2: Opcode 0110011 with funct3 000 decodes as ADD (funct7 0000000, op code 0), SUB (funct7 0100000, op 1) or MUL (funct7 0000001, op 2), and funct3 100 with funct7 0000001 decodes as DIV (op 3). Opcode 0000011 with funct3 010 decodes as LW (op 4). ADD and SUB go to unit 0, MUL and DIV to unit 1, and LW to unit 2.
- R3: For LW, `iss_imm` is bits 31:20 of the word sign-extended to 32 bits, and operand B is ready with value 0. For the register-register ops, `iss_imm` is 0.
- R4: `imem_addr` starts at 0 and grows by 4 after each cycle in which the word was issued or skipped.
- R5: An accepted instruction does not issue while `rob_full` is 1 or while every station of its unit is busy. In that case `imem_addr` holds, `iss_valid` is 0 in the next cycle, and the alias table does not change.
- R6: An issued instruction takes the lowest-numbered station of its unit whose busy bit is 0, and reports it on `iss_slot`.
- R7: A source with no pending writer is issued ready, with the register-file value and tag 0.
- R8: A source with a pending writer is issued not ready, with that writer's tag and value 0.
- R9: Register x0 as a source is always ready with value 0, whatever the register file returns. An instruction with destination x0 still issues, but it creates no alias, and a commit to x0 has no effect.
- R10: Each issue carries `rob_tag` as `iss_tag` and makes that tag the pending writer of its destination register for later instructions.
- R11: A commit clears a register's alias only when `commit_tag` equals the tag held for `commit_rd`. A commit with any other tag leaves the alias in place.
- R12: If a source's pending writer commits in the cycle that source is read, the source is issued ready with `commit_value`.
- R13: If an issue and a matching commit name the same destination register in one cycle, the new issue's alias is kept.
- R14: Any other encoding is skipped. It produces no issue and no alias change, and fetch moves on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Byte address of the instruction being decoded |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| rf_addr_a | output | 5 | Register-file read index, source A |
| rf_addr_b | output | 5 | Register-file read index, source B (0 for LW) |
| rf_data_a | input | 32 | Register-file value for `rf_addr_a` |
| rf_data_b | input | 32 | Register-file value for `rf_addr_b` |
| rob_full | input | 1 | Reorder buffer has no free entry |
| rob_tag | input | 3 | Tag of the next free reorder-buffer entry |
| alu_busy | input | 3 | Busy bits of the add/subtract stations |
| md_busy | input | 2 | Busy bits of the multiply/divide stations |
| ld_busy | input | 2 | Busy bits of the load stations |
| commit_valid | input | 1 | A reorder-buffer entry retires this cycle |
| commit_rd | input | 5 | Destination register of the retiring entry |
| commit_tag | input | 3 | Tag of the retiring entry |
| commit_value | input | 32 | Result of the retiring entry |
| iss_valid | output | 1 | Issue packet valid |
| iss_unit | output | 2 | Target unit: 0 add/sub, 1 mul/div, 2 load |
| iss_slot | output | 2 | Station index within the unit |
| iss_op | output | 3 | Operation code as in R2 |
| iss_rd | output | 5 | Destination register |
| iss_tag | output | 3 | Reorder-buffer tag of this instruction |
| iss_a_ready | output | 1 | Operand A holds a value |
| iss_a_value | output | 32 | Operand A value (0 when not ready) |
| iss_a_tag | output | 3 | Operand A producer tag (0 when ready) |
| iss_b_ready | output | 1 | Operand B holds a value |
| iss_b_value | output | 32 | Operand B value (0 when not ready) |
| iss_b_tag | output | 3 | Operand B producer tag (0 when ready) |
| iss_imm | output | 32 | Sign-extended load offset, 0 otherwise |

## Verification
The assertions rely on a few properties of the inputs. The busy vectors must reflect the stations truthfully. `rob_tag` must be the entry that the issue will occupy. A commit must name a register and tag together, as the reorder buffer would retire them. The decoder assertions also expect the instruction word to be driven from the first clock after reset. The bench keeps its own occupancy and tag bookkeeping from the issue packets it sees. It sets a station busy the cycle after it is granted, frees stations at random, and advances its tag counter once per issue. It draws commits from the alias state it models, and sometimes gives them a deliberately stale tag, so that forwarding, stale commits and same-register collisions all occur within the intended input contract.

// File: rtl/issue_pkg.sv
package issue_pkg;

  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_DIV = 3'd3,
    OP_LW  = 3'd4,
    OP_BAD = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    U_ALU  = 2'd0,
    U_MD   = 2'd1,
    U_LD   = 2'd2,
    U_NONE = 2'd3
  } unit_e;

  typedef struct packed {
    logic              ok;
    op_e               op;
    unit_e             unit;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs1;
    logic [RIDX_W-1:0] rs2;
    logic              use_rs2;
    logic [XLEN-1:0]   imm;
  } dec_t;

  // sign-extend a 12-bit field to the data width
  function automatic logic [XLEN-1:0] sext12(input logic [11:0] f);
    return {{(XLEN-12){f[11]}}, f};
  endfunction

  function automatic logic [XLEN-1:0] pc_step(input logic [XLEN-1:0] pc);
    return pc + XLEN'(4);
  endfunction

  function automatic dec_t decode_word(input logic [31:0] w);
    dec_t d;
    d      = '0;
    d.op   = OP_BAD;
    d.unit = U_NONE;
    d.rd   = w[11:7];
    d.rs1  = w[19:15];
    d.rs2  = w[24:20];
    unique case (w[6:0])
      7'b0110011: begin
        unique case ({w[31:25], w[14:12]})
          10'b0000000_000: begin d.ok = 1'b1; d.op = OP_ADD; d.unit = U_ALU; end
          10'b0100000_000: begin d.ok = 1'b1; d.op = OP_SUB; d.unit = U_ALU; end
          10'b0000001_000: begin d.ok = 1'b1; d.op = OP_MUL; d.unit = U_MD;  end
          10'b0000001_100: begin d.ok = 1'b1; d.op = OP_DIV; d.unit = U_MD;  end
          default: ;
        endcase
        d.use_rs2 = d.ok;
      end
      7'b0000011: begin
        if (w[14:12] == 3'b010) begin
          d.ok   = 1'b1;
          d.op   = OP_LW;
          d.unit = U_LD;
          d.imm  = sext12(w[31:20]);
        end
      end
      default: ;
    endcase
    return d;
  endfunction

  // operand value seen by a station: x0 reads zero, a pending source carries no value
  function automatic logic [XLEN-1:0] operand_value(input logic is_x0, input logic pend,
                                                    input logic fwd, input logic [XLEN-1:0] rf_v,
                                                    input logic [XLEN-1:0] cm_v);
    if (is_x0 || pend) return '0;
    if (fwd)           return cm_v;
    return rf_v;
  endfunction

endpackage

// File: rtl/issue_decode.sv
module issue_decode
  import issue_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] word,
  output dec_t        dec
);

  always_comb dec = decode_word(word);

  // loads go to the load unit and nothing else does
  assert_load_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec.ok |-> ((dec.op == OP_LW) == (dec.unit == U_LD)));

  // a rejected encoding requests no unit and no second source
  assert_reject_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !dec.ok |-> (dec.unit == U_NONE && !dec.use_rs2));

endmodule

// File: rtl/issue_pick.sv
module issue_pick #(
  parameter int N      = 3,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      busy,
  output logic              found,
  output logic [SLOT_W-1:0] idx
);

  // lowest free index wins: scan downward so the last hit is the smallest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = SLOT_W'(i);
      end
    end
  end

  assert_grant_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> !busy[idx]);

  assert_none_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (&busy));

endmodule

// File: rtl/issue_rat.sv
module issue_rat
  import issue_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int TAG_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0][RIDX_W-1:0]      rd_idx,
  output logic [1:0]                  pend,
  output logic [1:0]                  fwd,
  output logic [1:0][TAG_W-1:0]       pend_tag,
  input  logic                        wr_en,
  input  logic [RIDX_W-1:0]           wr_rd,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic                        cm_valid,
  input  logic [RIDX_W-1:0]           cm_rd,
  input  logic [TAG_W-1:0]            cm_tag
);

  logic [NREG-1:0]  v;
  logic [TAG_W-1:0] tg [NREG];
  logic             cm_clear;

  assign cm_clear = cm_valid && (cm_rd != '0) && v[cm_rd] && (tg[cm_rd] == cm_tag);

  for (genvar g = 0; g < 2; g++) begin : g_port
    logic held;
    logic hit;
    always_comb begin
      held        = v[rd_idx[g]] && (rd_idx[g] != '0);
      hit         = held && cm_valid && (cm_rd == rd_idx[g]) && (cm_tag == tg[rd_idx[g]]);
      pend[g]     = held && !hit;
      fwd[g]      = hit;
      pend_tag[g] = tg[rd_idx[g]];
    end
  end

  // commit clears first, a same-cycle issue to the same register overrides it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v <= '0;
      for (int i = 0; i < NREG; i++) tg[i] <= '0;
    end else begin
      if (cm_clear) v[cm_rd] <= 1'b0;
      if (wr_en && (wr_rd != '0)) begin
        v[wr_rd]  <= 1'b1;
        tg[wr_rd] <= wr_tag;
      end
    end
  end

  assert_alias_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_rd != '0) |=> (v[$past(wr_rd)] && tg[$past(wr_rd)] == $past(wr_tag)));

  assert_stale_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_clear && !(wr_en && wr_rd == cm_rd)) |=> v[$past(cm_rd)] == $past(v[cm_rd]));

  assert_match_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_clear && !(wr_en && wr_rd == cm_rd)) |=> !v[$past(cm_rd)]);

  assert_issue_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_clear && wr_en && wr_rd == cm_rd) |=> (v[$past(cm_rd)] && tg[$past(cm_rd)] == $past(wr_tag)));

  assert_x0_unaliased_R9: assert property (@(posedge clk) disable iff (!rst_n) !v[0]);

endmodule

// File: rtl/issue_front.sv
module issue_front
  import issue_pkg::*;
#(
  parameter int N_ALU     = 3,
  parameter int N_MD      = 2,
  parameter int N_LD      = 2,
  parameter int ROB_DEPTH = 8,
  parameter int NREG      = 32,
  localparam int TAG_W    = (ROB_DEPTH > 1) ? $clog2(ROB_DEPTH) : 1,
  localparam int MAXN     = (N_ALU > N_MD) ? ((N_ALU > N_LD) ? N_ALU : N_LD)
                                           : ((N_MD > N_LD) ? N_MD : N_LD),
  localparam int SLOT_W   = (MAXN > 1) ? $clog2(MAXN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [31:0]       imem_addr,
  input  logic [31:0]       imem_rdata,
  output logic [4:0]        rf_addr_a,
  output logic [4:0]        rf_addr_b,
  input  logic [31:0]       rf_data_a,
  input  logic [31:0]       rf_data_b,
  input  logic              rob_full,
  input  logic [TAG_W-1:0]  rob_tag,
  input  logic [N_ALU-1:0]  alu_busy,
  input  logic [N_MD-1:0]   md_busy,
  input  logic [N_LD-1:0]   ld_busy,
  input  logic              commit_valid,
  input  logic [4:0]        commit_rd,
  input  logic [TAG_W-1:0]  commit_tag,
  input  logic [31:0]       commit_value,
  output logic              iss_valid,
  output logic [1:0]        iss_unit,
  output logic [SLOT_W-1:0] iss_slot,
  output logic [2:0]        iss_op,
  output logic [4:0]        iss_rd,
  output logic [TAG_W-1:0]  iss_tag,
  output logic              iss_a_ready,
  output logic [31:0]       iss_a_value,
  output logic [TAG_W-1:0]  iss_a_tag,
  output logic              iss_b_ready,
  output logic [31:0]       iss_b_value,
  output logic [TAG_W-1:0]  iss_b_tag,
  output logic [31:0]       iss_imm
);

  dec_t                     dec;
  logic [31:0]              pc;
  logic [1:0][RIDX_W-1:0]   src_idx;
  logic [1:0]               src_pend, src_fwd;
  logic [1:0][TAG_W-1:0]    src_tag;
  logic [1:0][31:0]         rf_val;
  logic [1:0]               op_ready;
  logic [1:0][31:0]         op_val;
  logic [1:0][TAG_W-1:0]    op_tag;

  logic                     alu_found, md_found, ld_found;
  logic [SLOT_W-1:0]        alu_idx, md_idx, ld_idx;
  logic                     unit_free;
  logic [SLOT_W-1:0]        unit_idx;

  // named events shared by the logic and the assertions
  logic can_issue, skip, stall, advance;

  issue_decode u_dec (.clk(clk), .rst_n(rst_n), .word(imem_rdata), .dec(dec));

  assign src_idx[0] = dec.rs1;
  assign src_idx[1] = dec.use_rs2 ? dec.rs2 : '0;
  assign rf_addr_a  = src_idx[0];
  assign rf_addr_b  = src_idx[1];
  assign rf_val[0]  = rf_data_a;
  assign rf_val[1]  = rf_data_b;
  assign imem_addr  = pc;

  issue_pick #(.N(N_ALU), .SLOT_W(SLOT_W)) u_pick_alu (
    .clk(clk), .rst_n(rst_n), .busy(alu_busy), .found(alu_found), .idx(alu_idx));
  issue_pick #(.N(N_MD), .SLOT_W(SLOT_W)) u_pick_md (
    .clk(clk), .rst_n(rst_n), .busy(md_busy), .found(md_found), .idx(md_idx));
  issue_pick #(.N(N_LD), .SLOT_W(SLOT_W)) u_pick_ld (
    .clk(clk), .rst_n(rst_n), .busy(ld_busy), .found(ld_found), .idx(ld_idx));

  always_comb begin
    unique case (dec.unit)
      U_ALU:   begin unit_free = alu_found; unit_idx = alu_idx; end
      U_MD:    begin unit_free = md_found;  unit_idx = md_idx;  end
      U_LD:    begin unit_free = ld_found;  unit_idx = ld_idx;  end
      default: begin unit_free = 1'b0;      unit_idx = '0;      end
    endcase
  end

  assign can_issue = dec.ok && !rob_full && unit_free;
  assign skip      = !dec.ok;
  assign stall     = dec.ok && !can_issue;
  assign advance   = can_issue || skip;

  issue_rat #(.NREG(NREG), .TAG_W(TAG_W)) u_rat (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(src_idx), .pend(src_pend), .fwd(src_fwd), .pend_tag(src_tag),
    .wr_en(can_issue), .wr_rd(dec.rd), .wr_tag(rob_tag),
    .cm_valid(commit_valid), .cm_rd(commit_rd), .cm_tag(commit_tag));

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    logic is_x0;
    always_comb begin
      is_x0       = (src_idx[g] == '0);
      op_ready[g] = is_x0 || !src_pend[g];
      op_val[g]   = operand_value(is_x0, src_pend[g], src_fwd[g], rf_val[g], commit_value);
      op_tag[g]   = (!is_x0 && src_pend[g]) ? src_tag[g] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else if (advance) pc <= pc_step(pc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_valid   <= 1'b0;
      iss_unit    <= '0;
      iss_slot    <= '0;
      iss_op      <= '0;
      iss_rd      <= '0;
      iss_tag     <= '0;
      iss_a_ready <= 1'b0;
      iss_a_value <= '0;
      iss_a_tag   <= '0;
      iss_b_ready <= 1'b0;
      iss_b_value <= '0;
      iss_b_tag   <= '0;
      iss_imm     <= '0;
    end else begin
      iss_valid <= can_issue;
      if (can_issue) begin
        iss_unit    <= dec.unit;
        iss_slot    <= unit_idx;
        iss_op      <= dec.op;
        iss_rd      <= dec.rd;
        iss_tag     <= rob_tag;
        iss_a_ready <= op_ready[0];
        iss_a_value <= op_val[0];
        iss_a_tag   <= op_tag[0];
        iss_b_ready <= op_ready[1];
        iss_b_value <= op_val[1];
        iss_b_tag   <= op_tag[1];
        iss_imm     <= dec.imm;
      end
    end
  end

  assert_fetch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (imem_addr == $past(imem_addr) && !iss_valid));

  assert_fetch_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> imem_addr == $past(imem_addr) + 32'd4);

  assert_skip_silent_R14: assert property (@(posedge clk) disable iff (!rst_n)
    skip |=> !iss_valid);

  assert_rob_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rob_full |=> !iss_valid);

  assert_tag_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    can_issue |=> (iss_valid && iss_tag == $past(rob_tag)));

  assert_pending_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_a_ready) |-> iss_a_value == '0);

endmodule

// File: tb/issue_front_bench.sv
module issue_front_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata;
  logic [4:0]  rf_addr_a, rf_addr_b;
  logic [31:0] rf_data_a, rf_data_b;
  logic        rob_full;
  logic [2:0]  rob_tag;
  logic [2:0]  alu_busy;
  logic [1:0]  md_busy, ld_busy;
  logic        commit_valid;
  logic [4:0]  commit_rd;
  logic [2:0]  commit_tag;
  logic [31:0] commit_value;
  logic        iss_valid;
  logic [1:0]  iss_unit;
  logic [1:0]  iss_slot;
  logic [2:0]  iss_op;
  logic [4:0]  iss_rd;
  logic [2:0]  iss_tag;
  logic        iss_a_ready, iss_b_ready;
  logic [31:0] iss_a_value, iss_b_value, iss_imm;
  logic [2:0]  iss_a_tag, iss_b_tag;

  always #4 clk = ~clk;

  issue_front u_issue_front (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .rf_addr_a(rf_addr_a), .rf_addr_b(rf_addr_b), .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
    .rob_full(rob_full), .rob_tag(rob_tag), .alu_busy(alu_busy), .md_busy(md_busy),
    .ld_busy(ld_busy), .commit_valid(commit_valid), .commit_rd(commit_rd),
    .commit_tag(commit_tag), .commit_value(commit_value), .iss_valid(iss_valid),
    .iss_unit(iss_unit), .iss_slot(iss_slot), .iss_op(iss_op), .iss_rd(iss_rd),
    .iss_tag(iss_tag), .iss_a_ready(iss_a_ready), .iss_a_value(iss_a_value),
    .iss_a_tag(iss_a_tag), .iss_b_ready(iss_b_ready), .iss_b_value(iss_b_value),
    .iss_b_tag(iss_b_tag), .iss_imm(iss_imm));

  logic [31:0] imem   [64];
  logic [31:0] rf_mem [32];
  assign imem_rdata = imem[imem_addr[7:2]];
  assign rf_data_a  = rf_mem[rf_addr_a];
  assign rf_data_b  = rf_mem[rf_addr_b];

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct packed {
    logic        ok;
    logic [2:0]  op;
    logic [1:0]  unit;
    logic [4:0]  rd;
    logic [4:0]  ra;
    logic [4:0]  rb;
    logic [31:0] imm;
  } bd_t;

  // model state
  logic [31:0] m_pc;
  logic        m_v   [32];
  logic [2:0]  m_tag [32];
  string       m_note[32];
  logic [2:0]  m_rob;
  logic        pend_wr;
  logic [4:0]  pend_rd;
  logic [31:0] pend_val;
  // expected packet
  logic        e_valid;
  logic [1:0]  e_unit, e_slot;
  logic [2:0]  e_op, e_tag, e_at, e_bt;
  logic [4:0]  e_rd;
  logic        e_ar, e_br;
  logic [31:0] e_av, e_bv, e_imm;
  string       e_areq, e_breq, e_vreq;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] b,
                                        input logic [4:0] a, input logic [2:0] f3,
                                        input logic [4:0] d);
    return {f7, b, a, f3, d, 7'h33};
  endfunction

  function automatic logic [31:0] enc_ld(input logic [11:0] off, input logic [4:0] a,
                                         input logic [2:0] f3, input logic [4:0] d);
    return {off, a, f3, d, 7'h03};
  endfunction

  function automatic bd_t bdec(input logic [31:0] w);
    bd_t d;
    d      = '0;
    d.op   = 3'd7;
    d.unit = 2'd3;
    d.rd   = w[11:7];
    d.ra   = w[19:15];
    if (w[6:0] == 7'h33 && w[14:12] == 3'd0 && w[31:25] == 7'h00) begin d.ok = 1; d.op = 0; d.unit = 0; end
    if (w[6:0] == 7'h33 && w[14:12] == 3'd0 && w[31:25] == 7'h20) begin d.ok = 1; d.op = 1; d.unit = 0; end
    if (w[6:0] == 7'h33 && w[14:12] == 3'd0 && w[31:25] == 7'h01) begin d.ok = 1; d.op = 2; d.unit = 1; end
    if (w[6:0] == 7'h33 && w[14:12] == 3'd4 && w[31:25] == 7'h01) begin d.ok = 1; d.op = 3; d.unit = 1; end
    if (d.ok) d.rb = w[24:20];
    if (w[6:0] == 7'h03 && w[14:12] == 3'd2) begin
      d.ok = 1; d.op = 4; d.unit = 2; d.rb = 5'd0;
      d.imm = 32'($signed(w[31:20]));
    end
    return d;
  endfunction

  function automatic int first_free(input logic [3:0] b, input int n);
    for (int i = 0; i < n; i++) if (!b[i]) return i;
    return -1;
  endfunction

  task automatic src_exp(input logic [4:0] idx, output logic r, output logic [31:0] v,
                         output logic [2:0] t, output string rq);
    if (idx == 0) begin
      r = 1; v = 0; t = 0; rq = "R9";
    end else if (m_v[idx] && commit_valid && commit_rd == idx && commit_tag == m_tag[idx]) begin
      r = 1; v = commit_value; t = 0; rq = {"R12 ", m_note[idx]};
    end else if (m_v[idx]) begin
      r = 0; v = 0; t = m_tag[idx]; rq = {"R8 ", m_note[idx]};
    end else begin
      r = 1; v = rf_mem[idx]; t = 0; rq = {"R7 ", m_note[idx]};
    end
  endtask

  task automatic compare_outputs();
    chk("R4", "imem_addr", imem_addr, m_pc);
    chk(e_vreq, "iss_valid", 32'(iss_valid), 32'(e_valid));
    if (e_valid && iss_valid) begin
      chk("R2", "iss_unit", 32'(iss_unit), 32'(e_unit));
      chk("R2", "iss_op", 32'(iss_op), 32'(e_op));
      chk("R6", "iss_slot", 32'(iss_slot), 32'(e_slot));
      chk("R10", "iss_rd", 32'(iss_rd), 32'(e_rd));
      chk("R10", "iss_tag", 32'(iss_tag), 32'(e_tag));
      chk("R3", "iss_imm", iss_imm, e_imm);
      chk(e_areq, "a_ready", 32'(iss_a_ready), 32'(e_ar));
      chk(e_areq, "a_value", iss_a_value, e_av);
      chk(e_areq, "a_tag", 32'(iss_a_tag), 32'(e_at));
      chk(e_breq, "b_ready", 32'(iss_b_ready), 32'(e_br));
      chk(e_breq, "b_value", iss_b_value, e_bv);
      chk(e_breq, "b_tag", 32'(iss_b_tag), 32'(e_bt));
    end
  endtask

  task automatic step(input bit check_en);
    bd_t         d;
    int          fi;
    logic [3:0]  bv;
    logic        go, clr;
    if (check_en) compare_outputs();
    if (pend_wr) rf_mem[pend_rd] = pend_val;
    pend_wr = 0;
    // station and tag bookkeeping from the packet just seen
    for (int i = 0; i < 3; i++) if ($urandom % 3 == 0) alu_busy[i] = 1'b0;
    for (int i = 0; i < 2; i++) if ($urandom % 4 == 0) md_busy[i] = 1'b0;
    for (int i = 0; i < 2; i++) if ($urandom % 3 == 0) ld_busy[i] = 1'b0;
    if (e_valid) begin
      if (e_unit == 0) alu_busy[e_slot] = 1'b1;
      if (e_unit == 1) md_busy[e_slot[0]] = 1'b1;
      if (e_unit == 2) ld_busy[e_slot[0]] = 1'b1;
      m_rob = m_rob + 3'd1;
    end
    rob_full = ($urandom % 6 == 0);
    rob_tag  = m_rob;
    commit_valid = 1'b0;
    commit_rd    = 5'($urandom % 8);
    commit_tag   = 3'($urandom);
    commit_value = $urandom;
    if ($urandom % 2 == 0) begin
      commit_valid = 1'b1;
      if (m_v[commit_rd] && ($urandom % 4 != 0)) commit_tag = m_tag[commit_rd];
    end
    // expected result of the coming edge
    d  = bdec(imem[m_pc[7:2]]);
    bv = (d.unit == 0) ? {1'b0, alu_busy} : (d.unit == 1) ? {2'b11, md_busy} : {2'b11, ld_busy};
    fi = first_free(bv, (d.unit == 0) ? 3 : 2);
    go = d.ok && !rob_full && (fi >= 0);
    e_valid = go;
    e_vreq  = !d.ok ? "R14" : (go ? "R2" : "R5");
    if (go) begin
      e_unit = d.unit; e_op = d.op; e_rd = d.rd; e_tag = m_rob; e_imm = d.imm;
      e_slot = 2'(fi);
      src_exp(d.ra, e_ar, e_av, e_at, e_areq);
      src_exp(d.rb, e_br, e_bv, e_bt, e_breq);
      if (d.op == 3'd4) e_breq = "R3";
    end
    clr = commit_valid && commit_rd != 0 && m_v[commit_rd] && m_tag[commit_rd] == commit_tag;
    if (commit_valid && commit_rd != 0 && m_v[commit_rd] && !clr) m_note[commit_rd] = "R11";
    if (clr) begin
      m_v[commit_rd] = 1'b0;
      m_note[commit_rd] = "R11";
    end
    if (go && d.rd != 0) begin
      m_v[d.rd]    = 1'b1;
      m_tag[d.rd]  = m_rob;
      m_note[d.rd] = (clr && commit_rd == d.rd) ? "R13" : "R10";
    end
    if (!d.ok || go) m_pc = m_pc + 32'd4;
    if (commit_valid && commit_rd != 0) begin
      pend_wr = 1; pend_rd = commit_rd; pend_val = commit_value;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    commit_valid = 1'b0;
    rob_full = 1'b0;
    alu_busy = '0; md_busy = '0; ld_busy = '0;
    e_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "iss_valid in reset", 32'(iss_valid), 32'd0);
    chk("R1", "imem_addr in reset", imem_addr, 32'd0);
    if (pend_wr) rf_mem[pend_rd] = pend_val;
    pend_wr = 0;
    m_pc = 0;
    for (int i = 0; i < 32; i++) begin m_v[i] = 1'b0; m_note[i] = "R1"; end
    rst_n = 1'b1;
  endtask

  task automatic run(input int cycles);
    step(1'b0);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      step(1'b1);
    end
    @(negedge clk);
    compare_outputs();
  endtask

  initial begin
    void'($urandom(32'd7919));
    rst_n = 1'b0;
    m_rob = 0;
    pend_wr = 0;
    commit_rd = 0; commit_tag = 0; commit_value = 0; rob_tag = 0;
    for (int i = 0; i < 32; i++) begin
      rf_mem[i] = $urandom;
      m_tag[i]  = 0;
    end
    rf_mem[0] = 32'hDEAD_BEEF;   // x0 must still read as zero (R9)
    // directed corner words
    imem[0] = enc_ld(12'hFFC, 5'd2, 3'd2, 5'd3);           // LW x3,-4(x2): R3 negative offset
    imem[1] = enc_r(7'h00, 5'd0, 5'd3, 3'd0, 5'd0);        // ADD x0,x3,x0: R9
    imem[2] = enc_r(7'h20, 5'd3, 5'd3, 3'd0, 5'd4);        // SUB x4,x3,x3
    imem[3] = enc_r(7'h01, 5'd0, 5'd4, 3'd0, 5'd5);        // MUL x5,x4,x0
    imem[4] = enc_r(7'h01, 5'd4, 5'd5, 3'd4, 5'd6);        // DIV x6,x5,x4
    imem[5] = enc_r(7'h01, 5'd1, 5'd2, 3'd1, 5'd7);        // unsupported multiply variant: R14
    imem[6] = {12'h005, 5'd1, 3'd0, 5'd7, 7'h13};          // immediate add: R14
    imem[7] = enc_ld(12'h010, 5'd1, 3'd0, 5'd7);           // byte load: R14
    imem[8] = enc_ld(12'h7FF, 5'd0, 3'd2, 5'd7);           // LW x7,2047(x0)
    for (int i = 9; i < 64; i++) begin
      int k;
      logic [4:0] a, b, r;
      k = $urandom % 12;
      a = 5'($urandom % 8); b = 5'($urandom % 8); r = 5'($urandom % 8);
      case (k)
        0, 1, 2: imem[i] = enc_r(7'h00, b, a, 3'd0, r);
        3:       imem[i] = enc_r(7'h20, b, a, 3'd0, r);
        4, 5:    imem[i] = enc_r(7'h01, b, a, 3'd0, r);
        6, 7:    imem[i] = enc_r(7'h01, b, a, 3'd4, r);
        8, 9:    imem[i] = enc_ld(12'($urandom), a, 3'd2, r);
        10:      imem[i] = enc_r(7'h08, b, a, 3'd0, r);
        default: imem[i] = {12'($urandom), a, 3'd2, r, 7'h23};
      endcase
    end
    do_reset();
    run(800);
    do_reset();
    run(800);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 200000, 1600);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule